// File: doc/BRIEF.md
# UART Transmit Line-Mode Controller

This block sits between a UART's transmit queue and its transmit shift register and decides when a new character may begin. It supports three line arrangements. The first is a plain two-wire link, where the transmitter runs whenever data is queued. The second is a four-wire link with a request-to-send / clear-to-send handshake. The third is a half-duplex differential bus, where a line driver must be switched on around each burst. The bit timing, the shift register and the queues are outside this block.

The controller reads four inputs: a queue-not-empty flag, the transmitter busy flag, the far end's clear-to-send line and a receive-gap flag. The receive-gap flag comes from a receive-timeout unit and means that the line has been quiet for the required inter-packet gap. The block drives three outputs: request-to-send, the bus driver enable, and a start permit that the shift register samples while it is idle. In handshake mode, request-to-send follows pending work, and a start waits for a synchronised clear-to-send. In half-duplex mode, a burst may begin only after the receive gap has been signalled. The driver is switched on a programmable number of cycles before the first start bit. It stays on until the last stop bit has left and an optional tail has expired.

All pins are plain level signals. The block has no data stream, so there is no valid/ready pair. The transmitter treats `start_ok_o` as a level qualifier. It must raise `tx_busy_i` in the cycle after it accepts a start, and hold it until the final stop bit has been shifted out.

Top module: `uart_line_ctrl`

## Requirements
- R1: While `rst_n` is low, `rts_o`, `de_o` and `start_ok_o` are all low, whatever the other inputs are.
- R2: `mode_i` is decoded as follows: 0 is two-wire, 1 is four-wire handshake, 2 is half-duplex bus, and 3 behaves exactly like 0.
- R3: In two-wire mode, `rts_o` and `de_o` stay low and `start_ok_o` equals `fifo_nempty_i & ~tx_busy_i`. Clear-to-send and the receive gap have no effect.
- R4: In handshake mode, `rts_o` is registered. It is high one edge after a cycle in which data is queued or the transmitter is busy. It is low one edge after a cycle in which the queue is empty and the transmitter is idle.
- R5: In handshake mode, `cts_i` passes through SYNC_STAGES flip-flops. `start_ok_o` is `rts_o & cts_sync & fifo_nempty_i & ~tx_busy_i`, so a rise of `cts_i` can raise the permit no earlier than SYNC_STAGES edges later.
- R6: `start_ok_o` is never high while `tx_busy_i` is high. A clear-to-send drop during a character leaves `rts_o` high and blocks only the next start.
- R7: In half-duplex mode with the driver off, queued data does not turn the driver on and gets no permit while `rx_gap_i` is low.
- R8: In half-duplex mode with the driver off, a cycle with `fifo_nempty_i` and `rx_gap_i` both high raises `de_o` at the next edge. `start_ok_o` first rises exactly DE_LEAD edges after that.
- R9: Once the driver is on, further characters are permitted as `fifo_nempty_i & ~tx_busy_i`, without consulting `rx_gap_i` again.
- R10: `de_o` stays high while the transmitter is busy. After the first sampled cycle with an empty queue and an idle transmitter, it falls DE_TAIL+1 edges later.
- R11: Data queued during the tail returns the controller to driving at the next edge. There is no lead time and no gap check.
- R12: Leaving half-duplex mode turns `de_o` off at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Line mode (see R2) |
| fifo_nempty_i | input | 1 | Transmit queue holds at least one character |
| tx_busy_i | input | 1 | Shift register is sending a character |
| cts_i | input | 1 | Clear-to-send from far end, active high, asynchronous |
| rx_gap_i | input | 1 | Receive line quiet for the inter-packet gap |
| rts_o | output | 1 | Request-to-send, active high |
| de_o | output | 1 | Bus driver enable |
| start_ok_o | output | 1 | Shift register may begin a character |

## Verification
The bench builds the controller with SYNC_STAGES=2, DE_LEAD=2 and DE_TAIL=2, not with the defaults of 1 and 0. These values exercise both the lead counter and the tail counter. With them, the exact edge on which the permit first rises, and the edge on which the driver falls, can be separated from the neighbouring edges. A tail longer than one cycle also leaves room to queue data inside the tail and observe the return to driving. A steady-state vector table walks all four mode codes. Directed sequences then time the clear-to-send latency, the request-to-send edges and each half-duplex transition.

// File: rtl/ulc_pkg.sv
package ulc_pkg;

  typedef enum logic [1:0] {
    LM_TWO_WIRE  = 2'd0,
    LM_HANDSHAKE = 2'd1,
    LM_HALF_DUP  = 2'd2,
    LM_SPARE     = 2'd3
  } line_mode_e;

  typedef enum logic [1:0] {
    HD_IDLE  = 2'd0,
    HD_LEAD  = 2'd1,
    HD_DRIVE = 2'd2,
    HD_TAIL  = 2'd3
  } hd_state_e;

endpackage

// File: rtl/ulc_sync.sv
module ulc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ulc_flow.sv
module ulc_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fifo_nempty_i,
  input  logic tx_busy_i,
  input  logic cts_sync_i,
  output logic rts_o,
  output logic permit_o
);
  logic rts_q;

  // Request stays up while work is queued or a character is in flight.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= en_i & (fifo_nempty_i | tx_busy_i);
  end

  assign rts_o    = rts_q;
  assign permit_o = en_i & rts_q & cts_sync_i & fifo_nempty_i & ~tx_busy_i;
endmodule

// File: rtl/ulc_half.sv
module ulc_half #(
  parameter int DE_LEAD = 1,
  parameter int DE_TAIL = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fifo_nempty_i,
  input  logic tx_busy_i,
  input  logic rx_gap_i,
  output logic de_o,
  output logic permit_o
);
  import ulc_pkg::*;

  localparam int SPAN      = (DE_LEAD > DE_TAIL) ? DE_LEAD : DE_TAIL;
  localparam int CNT_W     = (SPAN > 2) ? $clog2(SPAN) : 1;
  localparam int LEAD_LAST = (DE_LEAD > 0) ? DE_LEAD - 1 : 0;
  localparam int TAIL_LAST = (DE_TAIL > 0) ? DE_TAIL - 1 : 0;

  hd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             drained;

  assign drained = ~fifo_nempty_i & ~tx_busy_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      state_d = HD_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        HD_IDLE: begin
          if (fifo_nempty_i && rx_gap_i) begin
            state_d = HD_LEAD;
            cnt_d   = '0;
          end
        end
        HD_LEAD: begin
          if (cnt_q == CNT_W'(LEAD_LAST)) state_d = HD_DRIVE;
          else                            cnt_d   = cnt_q + 1'b1;
        end
        HD_DRIVE: begin
          if (drained) begin
            cnt_d   = '0;
            state_d = (DE_TAIL == 0) ? HD_IDLE : HD_TAIL;
          end
        end
        HD_TAIL: begin
          if (fifo_nempty_i || tx_busy_i)      state_d = HD_DRIVE;
          else if (cnt_q == CNT_W'(TAIL_LAST)) state_d = HD_IDLE;
          else                                 cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = HD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HD_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign de_o     = (state_q != HD_IDLE);
  assign permit_o = (state_q == HD_DRIVE) & fifo_nempty_i & ~tx_busy_i;
endmodule

// File: rtl/uart_line_ctrl.sv
module uart_line_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DE_LEAD     = 1,
  parameter int DE_TAIL     = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       fifo_nempty_i,
  input  logic       tx_busy_i,
  input  logic       cts_i,
  input  logic       rx_gap_i,
  output logic       rts_o,
  output logic       de_o,
  output logic       start_ok_o
);
  import ulc_pkg::*;

  line_mode_e mode;
  logic       is_hs, is_hd;
  logic       cts_sync;
  logic       hs_permit, hd_permit, permit;

  assign mode  = line_mode_e'(mode_i);
  assign is_hs = (mode == LM_HANDSHAKE);
  assign is_hd = (mode == LM_HALF_DUP);

  ulc_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cts_i),
    .q_o   (cts_sync)
  );

  ulc_flow u_flow (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (is_hs),
    .fifo_nempty_i (fifo_nempty_i),
    .tx_busy_i     (tx_busy_i),
    .cts_sync_i    (cts_sync),
    .rts_o         (rts_o),
    .permit_o      (hs_permit)
  );

  ulc_half #(.DE_LEAD(DE_LEAD), .DE_TAIL(DE_TAIL)) u_half (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (is_hd),
    .fifo_nempty_i (fifo_nempty_i),
    .tx_busy_i     (tx_busy_i),
    .rx_gap_i      (rx_gap_i),
    .de_o          (de_o),
    .permit_o      (hd_permit)
  );

  always_comb begin
    unique case (mode)
      LM_HANDSHAKE: permit = hs_permit;
      LM_HALF_DUP:  permit = hd_permit;
      default:      permit = fifo_nempty_i & ~tx_busy_i;
    endcase
  end

  assign start_ok_o = rst_n & permit;
endmodule

// File: rtl/ulc_checker.sv
module ulc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       fifo_nempty_i,
  input logic       tx_busy_i,
  input logic       rx_gap_i,
  input logic       rts_o,
  input logic       de_o,
  input logic       start_ok_o
);
  // R1: outputs quiet under reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!rts_o && !de_o && !start_ok_o)
        else $error("reset outputs not low");
    end
  end

  p_plain_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd0 || mode_i == 2'd3) && $past(mode_i == 2'd0 || mode_i == 2'd3))
      |-> (!rts_o && !de_o));

  p_rts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i == 2'd1) && $past(tx_busy_i)) |-> rts_o);

  p_permit_rts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && start_ok_o) |-> rts_o);

  p_permit_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok_o |-> !tx_busy_i);

  p_gap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> $past(rx_gap_i && fifo_nempty_i));

  p_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> !start_ok_o);

  p_de_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && $past(mode_i == 2'd2) && $past(de_o) && $past(tx_busy_i)) |-> de_o);

  p_mode_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i != 2'd2) |-> !de_o);
endmodule

bind uart_line_ctrl ulc_checker u_ulc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .fifo_nempty_i (fifo_nempty_i),
  .tx_busy_i     (tx_busy_i),
  .rx_gap_i      (rx_gap_i),
  .rts_o         (rts_o),
  .de_o          (de_o),
  .start_ok_o    (start_ok_o)
);

// File: tb/uart_line_ctrl_bench.sv
module uart_line_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       nempty, busy, cts, gap;
  logic       rts, de, ok;
  int         checks = 0;
  int         failures = 0;

  always #4 clk = ~clk;

  uart_line_ctrl #(.SYNC_STAGES(2), .DE_LEAD(2), .DE_TAIL(2)) u_uart_line_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .fifo_nempty_i (nempty),
    .tx_busy_i     (busy),
    .cts_i         (cts),
    .rx_gap_i      (gap),
    .rts_o         (rts),
    .de_o          (de),
    .start_ok_o    (ok)
  );

  // {mode[1:0], nempty, busy, cts, gap, exp_rts, exp_de, exp_ok}
  localparam logic [8:0] VEC [13] = '{
    9'b00_1000_001, 9'b00_1111_000, 9'b00_0011_000, 9'b11_1001_001,
    9'b01_1010_101, 9'b01_1000_100, 9'b01_0110_100, 9'b01_0010_000,
    9'b10_1010_000, 9'b10_1001_011, 9'b10_1100_010, 9'b10_0000_000,
    9'b00_0000_000
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] m, input logic ne, input logic b,
                       input logic c, input logic g);
    mode = m; nempty = ne; busy = b; cts = c; gap = g;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    step(3);
    chk("R1", "rts in reset", rts, 1'b0);
    chk("R1", "de in reset", de, 1'b0);
    chk("R1", "start_ok in reset", ok, 1'b0);
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1);
    rst_n = 1'b1;
    step(2);

    // steady-state table
    for (int i = 0; i < 13; i++) begin
      string tag;
      drive(VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      step(4);
      case (VEC[i][8:7])
        2'd0:    tag = "R3";
        2'd1:    tag = "R4";
        2'd2:    tag = "R7";
        default: tag = "R2";
      endcase
      chk(tag, "rts", rts, VEC[i][2]);
      chk(tag, "de", de, VEC[i][1]);
      chk(tag, "start_ok", ok, VEC[i][0]);
    end

    // R5: clear-to-send latency
    drive(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(4);
    chk("R5", "rts with data", rts, 1'b1);
    chk("R5", "no permit without cts", ok, 1'b0);
    cts = 1'b1;
    step(1);
    chk("R5", "permit after 1 edge", ok, 1'b0);
    step(1);
    chk("R5", "permit after 2 edges", ok, 1'b1);

    // R4: request edges
    nempty = 1'b0;
    #1 chk("R4", "rts before edge", rts, 1'b1);
    step(1);
    chk("R4", "rts drop", rts, 1'b0);
    nempty = 1'b1;
    #1 chk("R4", "rts before rise", rts, 1'b0);
    step(1);
    chk("R4", "rts rise", rts, 1'b1);
    nempty = 1'b0; busy = 1'b1;
    step(3);
    chk("R4", "rts held while busy", rts, 1'b1);

    // R6: cts drop mid-character
    nempty = 1'b1;
    cts = 1'b0;
    step(3);
    chk("R6", "rts during char", rts, 1'b1);
    chk("R6", "no permit while busy", ok, 1'b0);
    busy = 1'b0;
    step(1);
    chk("R6", "next char blocked", ok, 1'b0);
    cts = 1'b1;
    step(2);
    chk("R6", "next char after cts", ok, 1'b1);

    // R8: driver lead
    drive(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    step(4);
    chk("R7", "driver off idle", de, 1'b0);
    nempty = 1'b1; gap = 1'b1;
    #1 chk("R8", "de before edge", de, 1'b0);
    step(1);
    chk("R8", "de rises", de, 1'b1);
    chk("R8", "no permit edge 1", ok, 1'b0);
    step(1);
    chk("R8", "no permit edge 2", ok, 1'b0);
    step(1);
    chk("R8", "permit edge 3", ok, 1'b1);

    // R9: no gap needed inside a burst
    gap = 1'b0; busy = 1'b1;
    step(2);
    chk("R9", "de during char", de, 1'b1);
    busy = 1'b0;
    #1 chk("R9", "next char permitted", ok, 1'b1);

    // R10: hold while busy, then tail
    busy = 1'b1; nempty = 1'b0;
    step(5);
    chk("R10", "de held while busy", de, 1'b1);
    busy = 1'b0;
    step(1);
    chk("R10", "de tail edge 1", de, 1'b1);
    step(1);
    chk("R10", "de tail edge 2", de, 1'b1);
    step(1);
    chk("R10", "de off edge 3", de, 1'b0);

    // R11: data during the tail
    nempty = 1'b1; gap = 1'b1;
    step(3);
    chk("R11", "permit before tail", ok, 1'b1);
    nempty = 1'b0; gap = 1'b0;
    step(1);
    chk("R11", "de in tail", de, 1'b1);
    nempty = 1'b1;
    #1 chk("R11", "no permit in tail", ok, 1'b0);
    step(1);
    chk("R11", "permit after return", ok, 1'b1);
    chk("R11", "de still on", de, 1'b1);

    // R12: leaving half-duplex mode
    mode = 2'd0;
    step(1);
    chk("R12", "de off after mode change", de, 1'b0);
    chk("R12", "plain permit", ok, 1'b1);

    finish_run();
  end
endmodule